// File: doc/BRIEF.md
# Synaptic Delay Ring Buffer

This block turns a stream of 32-bit synapse words into delayed input currents for a group of neurons. Each word carries four fields: a target neuron, a type bit that chooses excitatory or inhibitory input, a delay in ticks and an unsigned weight. The weight is added to an accumulator that belongs to the target neuron, the type, and the simulation tick that lies the given number of ticks after the current one. Each neuron has two rings of sixteen accumulators, one ring for each type. A tick pointer selects the slot that holds the input for the present tick.

The words of a synaptic row arrive back to back, one for each connection, with a valid/ready handshake. A single-cycle tick pulse ends the current tick. On that pulse the current slot of every neuron is cleared and the pointer moves forward by one. Between ticks, the neuron update logic asks for one neuron at a time through the read port and receives that neuron's excitatory and inhibitory sums for the current tick one cycle later.

Top module: `syn_ring_buffer`

## Requirements
- R1: After reset every accumulator holds zero, the tick pointer is at slot 0 and rdValid is low.
- R2: The word fields are weight [15:0], target neuron [23:16], type [24] (0 excitatory, 1 inhibitory) and delay [28:25]. An accepted word adds its weight to the accumulator for its target and type, and words to different neurons or slots accumulate independently.
- R3: A word accepted with delay d (1 to 15) lands in slot (pointer + d) mod 16. Its weight is read out after exactly d tick pulses and not before.
- R4: Excitatory and inhibitory weights are kept in separate accumulators and come out on rdExc and rdInh respectively.
- R5: A delay field of 0 is treated as a delay of 1, so a write never targets the slot currently being read.
- R6: An accumulator saturates at 2^ACC_W-1 instead of wrapping.
- R7: A tick pulse clears the current slot of every neuron for both types and advances the pointer by one, wrapping from 15 to 0. A read issued in the same cycle as the tick returns the value from before the clear.
- R8: Word bits [31:29] are ignored.
- R9: A word whose target is NEURONS or above is accepted and discarded. A read of an index NEURONS or above returns zero on both outputs.
- R10: wordReady is low exactly in the cycles where tickPulse is high. A word is taken only when wordValid and wordReady are both high.
- R11: rdReq with rdIdx in cycle t gives rdValid high in cycle t+1, with the current-slot sums that the accumulators held in cycle t. rdValid is low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A synapse word is offered |
| wordReady | output | 1 | The block can take a word this cycle |
| wordData | input | 32 | Synapse word |
| tickPulse | input | 1 | Ends the current simulation tick |
| rdReq | input | 1 | Read request for one neuron |
| rdIdx | input | 8 | Neuron index to read |
| rdValid | output | 1 | Read data is valid |
| rdExc | output | ACC_W | Excitatory sum for the current tick |
| rdInh | output | ACC_W | Inhibitory sum for the current tick |

## Verification
The bench builds the block with NEURONS = 8 and ACC_W = 18. With an 8-neuron group, read indices and targets just past the end of the group, as well as far-out values such as 200, can be reached with few cycles, and every neuron can be swept each tick. An 18-bit accumulator saturates after five full-scale weights, so the clamp is reached inside one short synaptic row. Random rows with ticks spread among them take the pointer around the ring several times, which exercises slot reuse after clearing.

// File: rtl/syn_ring_pkg.sv
`timescale 1ns/1ps
package syn_ring_pkg;

  localparam int WORD_W   = 32;
  localparam int WEIGHT_W = 16;
  localparam int NID_W    = 8;
  localparam int DELAY_W  = 4;
  localparam int SLOT_W   = DELAY_W;
  localparam int SLOTS    = 1 << DELAY_W;
  localparam int RSVD_W   = WORD_W - WEIGHT_W - NID_W - 1 - DELAY_W;

  // Synapse word, most significant field first.
  typedef struct packed {
    logic [RSVD_W-1:0]   rsvd;
    logic [DELAY_W-1:0]  delay;
    logic                isInh;
    logic [NID_W-1:0]    target;
    logic [WEIGHT_W-1:0] weight;
  } synWord_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                wrEn;
    logic                wrInh;
    logic [NID_W-1:0]    wrNeuron;
    logic [SLOT_W-1:0]   wrSlot;
    logic [WEIGHT_W-1:0] wrWeight;
    logic                clrEn;
    logic [SLOT_W-1:0]   clrSlot;
    logic                rdEn;
    logic [NID_W-1:0]    rdNeuron;
    logic [SLOT_W-1:0]   rdSlot;
  } ringStrobe_t;

endpackage

// File: rtl/syn_ring_ctrl.sv
`timescale 1ns/1ps
module syn_ring_ctrl
  import syn_ring_pkg::*;
#(
  parameter int NEURONS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              tickPulse,
  input  logic              rdReq,
  input  logic [NID_W-1:0]  rdIdx,
  output logic              wordReady,
  output ringStrobe_t       strb
);

  localparam logic [NID_W:0] NEURON_LIM = (NID_W+1)'(NEURONS);

  logic [SLOT_W-1:0] tickPtr;
  logic [SLOT_W-1:0] effDelay;
  logic              targetOk;
  synWord_t          wordIn;

  assign wordIn = synWord_t'(wordData);

  // Delay zero is promoted to one so the slot being read is never written (R5).
  always_comb begin
    effDelay = (wordIn.delay == '0) ? SLOT_W'(1) : wordIn.delay;
  end

  assign targetOk  = ({1'b0, wordIn.target} < NEURON_LIM);
  assign wordReady = !tickPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickPtr <= '0;
    end else if (tickPulse) begin
      tickPtr <= tickPtr + SLOT_W'(1);
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrEn     = wordValid && wordReady && targetOk;
    strb.wrInh    = wordIn.isInh;
    strb.wrNeuron = wordIn.target;
    strb.wrSlot   = tickPtr + effDelay;
    strb.wrWeight = wordIn.weight;
    strb.clrEn    = tickPulse;
    strb.clrSlot  = tickPtr;
    strb.rdEn     = rdReq;
    strb.rdNeuron = rdIdx;
    strb.rdSlot   = tickPtr;
  end

endmodule

// File: rtl/syn_ring_dp.sv
`timescale 1ns/1ps
module syn_ring_dp
  import syn_ring_pkg::*;
#(
  parameter int NEURONS = 32,
  parameter int ACC_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      strb,
  output logic             rdValid,
  output logic [ACC_W-1:0] rdExc,
  output logic [ACC_W-1:0] rdInh
);

  localparam int NIDX_W = (NEURONS > 1) ? $clog2(NEURONS) : 1;
  localparam logic [NID_W:0] NEURON_LIM = (NID_W+1)'(NEURONS);

  logic [ACC_W-1:0] excQ [NEURONS][SLOTS];
  logic [ACC_W-1:0] inhQ [NEURONS][SLOTS];
  logic [NEURONS-1:0] hitWr;
  logic [NIDX_W-1:0]  rdPick;
  logic               rdInRange;

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] acc,
                                              input logic [WEIGHT_W-1:0] w);
    logic [ACC_W:0] sum;
    sum = {1'b0, acc} + (ACC_W+1)'(w);
    return sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  endfunction

  // Per-neuron write select.
  for (genvar n = 0; n < NEURONS; n++) begin : gHit
    assign hitWr[n] = strb.wrEn && (strb.wrNeuron == NID_W'(n));
  end

  assign rdPick    = strb.rdNeuron[NIDX_W-1:0];
  assign rdInRange = ({1'b0, strb.rdNeuron} < NEURON_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdExc   <= '0;
      rdInh   <= '0;
      for (int n = 0; n < NEURONS; n++) begin
        for (int s = 0; s < SLOTS; s++) begin
          excQ[n][s] <= '0;
          inhQ[n][s] <= '0;
        end
      end
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) begin
        if (rdInRange) begin
          rdExc <= excQ[rdPick][strb.rdSlot];
          rdInh <= inhQ[rdPick][strb.rdSlot];
        end else begin
          rdExc <= '0;
          rdInh <= '0;
        end
      end
      for (int n = 0; n < NEURONS; n++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (strb.clrEn && strb.clrSlot == SLOT_W'(s)) begin
            excQ[n][s] <= '0;
            inhQ[n][s] <= '0;
          end else if (hitWr[n] && strb.wrSlot == SLOT_W'(s)) begin
            if (strb.wrInh) begin
              inhQ[n][s] <= satAdd(inhQ[n][s], strb.wrWeight);
            end else begin
              excQ[n][s] <= satAdd(excQ[n][s], strb.wrWeight);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/syn_ring_buffer.sv
`timescale 1ns/1ps
module syn_ring_buffer
  import syn_ring_pkg::*;
#(
  parameter int NEURONS = 32,
  parameter int ACC_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  output logic             wordReady,
  input  logic [31:0]      wordData,
  input  logic             tickPulse,
  input  logic             rdReq,
  input  logic [7:0]       rdIdx,
  output logic             rdValid,
  output logic [ACC_W-1:0] rdExc,
  output logic [ACC_W-1:0] rdInh
);

  ringStrobe_t strb;

  syn_ring_ctrl #(.NEURONS(NEURONS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .wordData  (wordData),
    .tickPulse (tickPulse),
    .rdReq     (rdReq),
    .rdIdx     (rdIdx),
    .wordReady (wordReady),
    .strb      (strb)
  );

  syn_ring_dp #(.NEURONS(NEURONS), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdValid (rdValid),
    .rdExc   (rdExc),
    .rdInh   (rdInh)
  );

endmodule

// File: rtl/syn_ring_chk.sv
`timescale 1ns/1ps
module syn_ring_chk
  import syn_ring_pkg::*;
#(
  parameter int NEURONS = 32,
  parameter int ACC_W   = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             wordReady,
  input logic             tickPulse,
  input logic             rdReq,
  input logic [7:0]       rdIdx,
  input logic             rdValid,
  input logic [ACC_W-1:0] rdExc,
  input logic [ACC_W-1:0] rdInh,
  input ringStrobe_t      strb
);

  // R10
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> !wordReady);

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  // R9
  oor_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && ({1'b0, rdIdx} >= 9'(NEURONS))) |=> (rdExc == '0 && rdInh == '0));

  // R5
  no_self_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.wrSlot != strb.rdSlot));

endmodule

bind syn_ring_buffer syn_ring_chk #(.NEURONS(NEURONS), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wordReady (wordReady),
  .tickPulse (tickPulse),
  .rdReq     (rdReq),
  .rdIdx     (rdIdx),
  .rdValid   (rdValid),
  .rdExc     (rdExc),
  .rdInh     (rdInh),
  .strb      (strb)
);

// File: tb/syn_ring_buffer_bench.sv
`timescale 1ns/1ps
module syn_ring_buffer_bench;

  localparam int NEURONS = 8;
  localparam int ACC_W   = 18;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wordValid = 1'b0;
  logic             wordReady;
  logic [31:0]      wordData = '0;
  logic             tickPulse = 1'b0;
  logic             rdReq = 1'b0;
  logic [7:0]       rdIdx = '0;
  logic             rdValid;
  logic [ACC_W-1:0] rdExc;
  logic [ACC_W-1:0] rdInh;

  always #4 clk = ~clk;

  syn_ring_buffer #(.NEURONS(NEURONS), .ACC_W(ACC_W)) u_syn_ring_buffer (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordReady(wordReady),
    .wordData(wordData), .tickPulse(tickPulse), .rdReq(rdReq), .rdIdx(rdIdx),
    .rdValid(rdValid), .rdExc(rdExc), .rdInh(rdInh)
  );

  // Behavioural reference
  int    refExc [NEURONS][16];
  int    refInh [NEURONS][16];
  int    refPtr;
  bit    expValid;
  int    expExc, expInh;
  string curReq = "R1";
  int    checks = 0, fails = 0;
  bit    done = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (refExc[n, s]) begin refExc[n][s] = 0; refInh[n][s] = 0; end
      refPtr = 0; expValid = 0; expExc = 0; expInh = 0;
    end else begin
      expValid = rdReq;
      if (rdReq) begin
        if (rdIdx < NEURONS) begin
          expExc = refExc[rdIdx][refPtr];
          expInh = refInh[rdIdx][refPtr];
        end else begin
          expExc = 0; expInh = 0;
        end
      end
      if (wordValid && !tickPulse) begin
        int w, tgt, d, slot;
        w = wordData[15:0]; tgt = wordData[23:16]; d = wordData[28:25];
        if (d == 0) d = 1;
        slot = (refPtr + d) % 16;
        if (tgt < NEURONS) begin
          if (wordData[24]) refInh[tgt][slot] = (refInh[tgt][slot] + w > ACC_MAX) ? ACC_MAX : refInh[tgt][slot] + w;
          else              refExc[tgt][slot] = (refExc[tgt][slot] + w > ACC_MAX) ? ACC_MAX : refExc[tgt][slot] + w;
        end
      end
      if (tickPulse) begin
        for (int n = 0; n < NEURONS; n++) begin refExc[n][refPtr] = 0; refInh[n][refPtr] = 0; end
        refPtr = (refPtr + 1) % 16;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareOut();
    check(rdValid == expValid, "R11", "rdValid", rdValid, expValid);
    if (expValid) begin
      check(rdExc == ACC_W'(expExc), curReq, "rdExc", rdExc, expExc);
      check(rdInh == ACC_W'(expInh), curReq, "rdInh", rdInh, expInh);
    end
  endtask

  task automatic cyc(bit v, logic [31:0] w, bit t, bit r, logic [7:0] idx);
    @(negedge clk);
    compareOut();
    wordValid = v; wordData = w; tickPulse = t; rdReq = r; rdIdx = idx;
    #1;
    check(wordReady == !t, "R10", "wordReady", wordReady, !t);
  endtask

  function automatic logic [31:0] mkWord(int weight, int tgt, bit inh, int delay, int rsvd);
    return {3'(rsvd), 4'(delay), inh, 8'(tgt), 16'(weight)};
  endfunction

  task automatic tickAndReadAll();
    cyc(0, 0, 1, 1, 0);
    for (int i = 0; i < NEURONS; i++) cyc(0, 0, 0, 1, 8'(i));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(rdValid == 1'b0, "R1", "rdValid in reset", rdValid, 0);
    end
    rstN = 1'b1;
    curReq = "R1";
    for (int i = 0; i < NEURONS; i++) cyc(0, 0, 0, 1, 8'(i));

    // R2 / R3: delay 3 excitatory word, appears after 3 ticks only
    curReq = "R3";
    cyc(1, mkWord(100, 2, 0, 3, 0), 0, 0, 0);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 1, 1, 2);
      cyc(0, 0, 0, 1, 2);
    end

    // R4: separate excitatory and inhibitory sums
    curReq = "R4";
    cyc(1, mkWord(300, 5, 0, 2, 0), 0, 0, 0);
    cyc(1, mkWord(77, 5, 1, 2, 0), 0, 0, 0);
    cyc(1, mkWord(11, 5, 1, 2, 0), 0, 0, 0);
    repeat (3) begin cyc(0, 0, 1, 1, 5); cyc(0, 0, 0, 1, 5); end

    // R5: delay zero acts as one
    curReq = "R5";
    cyc(1, mkWord(42, 1, 0, 0, 0), 0, 1, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 1, 1, 1);
    cyc(0, 0, 0, 1, 1);

    // R6: saturation with full-scale weights
    curReq = "R6";
    repeat (6) cyc(1, mkWord(65535, 3, 0, 2, 0), 0, 0, 0);
    repeat (6) cyc(1, mkWord(65535, 3, 1, 2, 0), 0, 0, 0);
    repeat (3) begin cyc(0, 0, 1, 1, 3); cyc(0, 0, 0, 1, 3); end

    // R8: reserved bits ignored
    curReq = "R8";
    cyc(1, mkWord(500, 4, 0, 1, 7), 0, 0, 0);
    cyc(1, mkWord(9, 4, 1, 1, 5), 0, 0, 0);
    cyc(0, 0, 1, 1, 4);
    cyc(0, 0, 0, 1, 4);

    // R9: out-of-range targets discarded, out-of-range reads give zero
    curReq = "R9";
    cyc(1, mkWord(1234, 200, 0, 1, 0), 0, 0, 0);
    cyc(1, mkWord(1234, NEURONS, 1, 1, 0), 0, 1, 200);
    cyc(0, 0, 0, 1, 8'(NEURONS));
    tickAndReadAll();

    // R7: slot cleared on tick, read in tick cycle sees pre-clear value, ring wraps
    curReq = "R7";
    cyc(1, mkWord(800, 6, 0, 15, 0), 0, 0, 0);
    cyc(1, mkWord(60, 6, 1, 1, 0), 0, 0, 0);
    repeat (18) begin cyc(0, 0, 1, 1, 6); cyc(0, 0, 0, 1, 6); end

    // R2: random rows with ticks and reads interleaved
    curReq = "R2";
    for (int k = 0; k < 600; k++) begin
      bit v, t, r;
      v = ($urandom % 3) != 0;
      t = ($urandom % 10) == 0;
      r = ($urandom % 2) == 0;
      cyc(v, mkWord($urandom % 65536, $urandom % (NEURONS + 2), $urandom % 2,
                    $urandom % 16, $urandom % 8),
          t, r, 8'($urandom % (NEURONS + 2)));
    end
    for (int k = 0; k < 16; k++) tickAndReadAll();

    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    done = 1;
    finishRun();
  end

endmodule